// File: doc/BRIEF.md
# Serial EEPROM Page Write Controller

This block is the device-side write path of a small serial EEPROM with a 128-byte array. A serial front end, already decoded to byte level, gives it a word address and then a stream of data bytes. The controller acknowledges each byte and gathers the bytes in an eight-slot page latch. A Stop at a byte boundary commits the loaded slots to the array through a synchronous write port. The commit runs inside a fixed self-timed busy window.

Only the low three bits of the word address advance from byte to byte. A transaction therefore never leaves its starting page. Bytes past the end of the page wrap to its first location and replace what that transaction loaded there earlier. A Stop that arrives in the middle of a byte discards the transaction. A Stop that arrives before any data byte ends the transaction without starting a write.

The control logic is a four-state machine:
- `PW_IDLE` waits for an address and moves to `PW_LOAD` when `addr_vld` is high.
- `PW_LOAD` collects bytes. `stop_mid` returns it to `PW_IDLE` and aborts the transaction. `stop` moves it to `PW_COMMIT` if at least one byte is held, and to `PW_IDLE` otherwise.
- `PW_COMMIT` walks the page slots, one slot per cycle, and moves to `PW_SETTLE` after the last slot.
- `PW_SETTLE` holds busy until the count of `TWR_CYCLES` is reached, then returns to `PW_IDLE`.

Top module: `eeprom_page_writer`

## Requirements
- R1: `addr_vld` seen in `PW_IDLE` captures word address bits 6..0 of `addr_in`. Bit 7 is ignored, so 0x90 and 0x10 select the same location.
- R2: Each `data_vld` seen in `PW_LOAD` without `stop_mid` raises `ack` for exactly the following cycle.
- R3: After each data byte only address bits 2..0 advance. Every array write of one transaction has the same bits 6..3 as its start address.
- R4: When bits 2..0 pass 7 they wrap to 0 in the same page. A later byte replaces the earlier one in that slot, and each location is written at most once per commit, with its final value.
- R5: Only the slots loaded in the transaction are written. The other locations of the page keep their contents.
- R6: A `stop` in `PW_LOAD` with at least one byte held starts the commit. The writes are issued in ascending slot order, one per cycle, within the first eight busy cycles.
- R7: `busy` goes high in the cycle after the committing `stop` and stays high for exactly `TWR_CYCLES` cycles.
- R8: `stop_mid` in `PW_LOAD` aborts the transaction. No array write follows, `busy` stays low, and a later transaction works normally.
- R9: A `stop` after the address but before any data byte produces no array write and does not raise `busy`.
- R10: While `busy` is high, and in `PW_IDLE`, `data_vld` produces no `ack` and no array write. While `busy` is high, `addr_vld` has no effect.
- R11: A `data_vld` and a `stop` in the same cycle latch and acknowledge that byte, and the commit includes it.
- R12: After reset, `busy`, `ack` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_vld | input | 1 | Address byte strobe |
| addr_in | input | 8 | Address byte; bit 7 ignored |
| data_vld | input | 1 | Data byte strobe |
| data_in | input | 8 | Data byte |
| stop | input | 1 | Stop received at a byte boundary |
| stop_mid | input | 1 | Stop received inside a byte |
| ack | output | 1 | Acknowledge for the byte strobed in the previous cycle |
| busy | output | 1 | Self-timed write cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 7 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The closing data byte and the Stop can arrive in the same cycle, so latching a byte and starting the commit meet on one clock edge. The bench drives `data_vld` and `stop` together after an earlier byte. It then expects `ack` in the next cycle, a busy window of full length, and that byte written at the next slot next to the earlier one. A second collision is forced by strobing an address and a byte while `busy` is high. That must produce no `ack`, and the later array contents must show that the strobes were ignored.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
    typedef enum logic [1:0] {
        PW_IDLE   = 2'd0,
        PW_LOAD   = 2'd1,
        PW_COMMIT = 2'd2,
        PW_SETTLE = 2'd3
    } pw_state_e;
endpackage

// File: rtl/eeprom_pw_latch.sv
module eeprom_pw_latch #(
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 load,
    input  logic [PAGE_BITS-1:0] start_slot,
    input  logic                 push,
    input  logic [DATA_W-1:0]    push_data,
    input  logic [PAGE_BITS-1:0] rd_slot,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic                 any_valid
);
    localparam int SLOTS = 1 << PAGE_BITS;

    logic [DATA_W-1:0]    data_q [SLOTS];
    logic [SLOTS-1:0]     valid_q;
    logic [PAGE_BITS-1:0] ptr_q;

    // slot pointer wraps naturally on the low page bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= start_slot;
        end else if (push) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                data_q[i] <= '0;
            end
        end else if (clear) begin
            valid_q <= '0;
        end else if (push) begin
            valid_q[ptr_q] <= 1'b1;
            data_q[ptr_q]  <= push_data;
        end
    end

    assign rd_data   = data_q[rd_slot];
    assign rd_valid  = valid_q[rd_slot];
    assign any_valid = |valid_q;
endmodule

// File: rtl/eeprom_pw_timer.sv
module eeprom_pw_timer #(
    parameter int TWR_CYCLES = 200
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run,
    output logic [$clog2(TWR_CYCLES)-1:0] count,
    output logic                          last
);
    localparam int CNT_W = $clog2(TWR_CYCLES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (run) begin
            count <= count + 1'b1;
        end else begin
            count <= '0;
        end
    end

    assign last = (count == CNT_W'(TWR_CYCLES - 1));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_pw_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 8,
    parameter int PAGE_BITS  = 3,
    parameter int TWR_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_vld,
    input  logic [ADDR_W:0]   addr_in,
    input  logic              data_vld,
    input  logic [DATA_W-1:0] data_in,
    input  logic              stop,
    input  logic              stop_mid,
    output logic              ack,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int ROW_W = ADDR_W - PAGE_BITS;
    localparam int SLOTS = 1 << PAGE_BITS;
    localparam int CNT_W = $clog2(TWR_CYCLES);

    pw_state_e state_q, state_d;
    logic [ROW_W-1:0]  row_q;
    logic              ack_q;

    logic              accept_addr, push, abort;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid, any_valid;
    logic [CNT_W-1:0]  count;
    logic              last, run;

    assign accept_addr = (state_q == PW_IDLE) && addr_vld;
    assign abort       = (state_q == PW_LOAD) && stop_mid;
    assign push        = (state_q == PW_LOAD) && data_vld && !stop_mid;
    assign run         = (state_q == PW_COMMIT) || (state_q == PW_SETTLE);

    eeprom_pw_latch #(
        .DATA_W   (DATA_W),
        .PAGE_BITS(PAGE_BITS)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept_addr || abort),
        .load      (accept_addr),
        .start_slot(addr_in[PAGE_BITS-1:0]),
        .push      (push),
        .push_data (data_in),
        .rd_slot   (count[PAGE_BITS-1:0]),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    eeprom_pw_timer #(
        .TWR_CYCLES(TWR_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .count(count),
        .last (last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE: begin
                if (addr_vld) state_d = PW_LOAD;
            end
            PW_LOAD: begin
                if (stop_mid) begin
                    state_d = PW_IDLE;
                end else if (stop) begin
                    state_d = (any_valid || data_vld) ? PW_COMMIT : PW_IDLE;
                end
            end
            PW_COMMIT: begin
                if (count == CNT_W'(SLOTS - 1)) state_d = PW_SETTLE;
            end
            PW_SETTLE: begin
                if (last) state_d = PW_IDLE;
            end
            default: state_d = PW_IDLE;
        endcase
    end

    // state, row and acknowledge registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PW_IDLE;
            row_q   <= '0;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= push;
            if (accept_addr) row_q <= addr_in[ADDR_W-1:PAGE_BITS];
        end
    end

    // outputs
    always_comb begin
        busy      = run;
        ack       = ack_q;
        mem_we    = (state_q == PW_COMMIT) && rd_valid;
        mem_addr  = {row_q, count[PAGE_BITS-1:0]};
        mem_wdata = rd_data;
    end
endmodule

// File: rtl/eeprom_pw_checker.sv
module eeprom_pw_checker #(
    parameter int ADDR_W     = 7,
    parameter int PAGE_BITS  = 3,
    parameter int TWR_CYCLES = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              data_vld,
    input logic              stop_mid,
    input logic              ack,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int RUN_W = $clog2(TWR_CYCLES + 2);
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else run_q <= '0;
    end

    p_ack_follows_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(data_vld));

    p_no_ack_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !$past(busy));

    p_row_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (mem_addr[ADDR_W-1:PAGE_BITS] == $past(mem_addr[ADDR_W-1:PAGE_BITS])));

    p_write_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_busy_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(TWR_CYCLES)));

    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mid && !busy) |=> !busy);
endmodule

bind eeprom_page_writer eeprom_pw_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .TWR_CYCLES(TWR_CYCLES)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_vld(data_vld),
    .stop_mid(stop_mid),
    .ack     (ack),
    .busy    (busy),
    .mem_we  (mem_we),
    .mem_addr(mem_addr)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
    localparam int TWR = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_vld = 1'b0;
    logic [7:0] addr_in = '0;
    logic       data_vld = 1'b0;
    logic [7:0] data_in = '0;
    logic       stop = 1'b0;
    logic       stop_mid = 1'b0;
    logic       ack, busy, mem_we;
    logic [6:0] mem_addr;
    logic [7:0] mem_wdata;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int wr_n = 0;
    logic [6:0] first_wr, last_wr;
    logic       order_ok;
    logic [7:0] obs [128];
    logic [7:0] exp_m [128];
    bit done = 0;

    always #10 clk = ~clk;

    eeprom_page_writer #(.TWR_CYCLES(TWR)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_in(addr_in),
        .data_vld(data_vld), .data_in(data_in), .stop(stop), .stop_mid(stop_mid),
        .ack(ack), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // array model fed by the write port, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (wr_n == 0) first_wr = mem_addr;
            else if (mem_addr <= last_wr) order_ok = 1'b0;
            last_wr = mem_addr;
            obs[mem_addr] = mem_wdata;
            wr_n++;
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic begin_txn(input logic [7:0] a);
        wr_n = 0; order_ok = 1'b1;
        @(negedge clk); addr_vld = 1'b1; addr_in = a;
        @(negedge clk); addr_vld = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk); data_vld = 1'b1; data_in = d;
        @(negedge clk); data_vld = 1'b0;
        check(ack === 1'b1, "R2 ack after byte", ack, 1);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy === 1'b1 && n < TWR + 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic end_txn(input bit with_byte, input logic [7:0] d);
        int n;
        @(negedge clk); stop = 1'b1;
        if (with_byte) begin data_vld = 1'b1; data_in = d; end
        @(negedge clk); stop = 1'b0; data_vld = 1'b0;
        if (with_byte) check(ack === 1'b1, "R11 ack on byte with stop", ack, 1);
        wait_idle(n);
        check(n == TWR, "R7 busy length", n, TWR);
    endtask

    task automatic check_mem(input int a, input string tag);
        check(obs[a] === exp_m[a], tag, obs[a], exp_m[a]);
    endtask

    task automatic t_reset();
        check(busy === 1'b0, "R12 busy after reset", busy, 0);
        check(ack === 1'b0, "R12 ack after reset", ack, 0);
        check(mem_we === 1'b0, "R12 mem_we after reset", mem_we, 0);
    endtask

    task automatic t_full_page();
        begin_txn(8'h90);
        for (int i = 0; i < 8; i++) begin
            send_byte(8'hA0 + 8'(i));
            exp_m[7'h10 + i] = 8'hA0 + 8'(i);
        end
        end_txn(0, 8'h00);
        for (int i = 0; i < 8; i++) check_mem(7'h10 + i, "R1 full page contents");
        check(wr_n == 8, "R6 write count", wr_n, 8);
        check(first_wr == 7'h10 && last_wr == 7'h17 && order_ok, "R6 ascending order", first_wr, 7'h10);
    endtask

    task automatic t_partial_wrap();
        begin_txn(8'h16);
        send_byte(8'h51); exp_m[7'h16] = 8'h51;
        send_byte(8'h52); exp_m[7'h17] = 8'h52;
        send_byte(8'h53); exp_m[7'h10] = 8'h53;
        end_txn(0, 8'h00);
        check(wr_n == 3, "R5 only loaded slots written", wr_n, 3);
        check_mem(7'h10, "R3 wrap to slot 0 of same page");
        check_mem(7'h16, "R3 start slot");
        check_mem(7'h17, "R3 last slot");
        for (int a = 7'h11; a <= 7'h15; a++) check_mem(a, "R5 unloaded kept");
        check(obs[7'h18] === exp_m[7'h18], "R3 next page untouched", obs[7'h18], exp_m[7'h18]);
    endtask

    task automatic t_overrun();
        begin_txn(8'h41);
        for (int i = 0; i < 10; i++) begin
            send_byte(8'hC0 + 8'(i));
            exp_m[7'h40 + ((1 + i) % 8)] = 8'hC0 + 8'(i);
        end
        end_txn(0, 8'h00);
        check(wr_n == 8, "R4 one write per slot", wr_n, 8);
        for (int a = 7'h40; a < 7'h48; a++) check_mem(a, "R4 final values");
    endtask

    task automatic t_abort();
        begin_txn(8'h30);
        send_byte(8'h11);
        send_byte(8'h12);
        @(negedge clk); stop_mid = 1'b1;
        @(negedge clk); stop_mid = 1'b0;
        repeat (10) @(negedge clk);
        check(busy === 1'b0, "R8 no busy after abort", busy, 0);
        check(wr_n == 0, "R8 no writes after abort", wr_n, 0);
        begin_txn(8'h30);
        send_byte(8'h77); exp_m[7'h30] = 8'h77;
        end_txn(0, 8'h00);
        check(wr_n == 1, "R8 later transaction writes", wr_n, 1);
        check_mem(7'h30, "R8 later transaction data");
        check_mem(7'h31, "R8 aborted byte discarded");
    endtask

    task automatic t_empty_stop();
        begin_txn(8'h20);
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        check(busy === 1'b0, "R9 no busy on empty stop", busy, 0);
        repeat (10) @(negedge clk);
        check(wr_n == 0, "R9 no writes on empty stop", wr_n, 0);
    endtask

    task automatic t_ignored();
        int n;
        @(negedge clk); data_vld = 1'b1; data_in = 8'h99;
        @(negedge clk); data_vld = 1'b0;
        check(ack === 1'b0, "R10 no ack in idle", ack, 0);
        begin_txn(8'h50);
        send_byte(8'h3C); exp_m[7'h50] = 8'h3C;
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        repeat (3) @(negedge clk);
        addr_vld = 1'b1; addr_in = 8'h60;
        @(negedge clk); addr_vld = 1'b0; data_vld = 1'b1; data_in = 8'hEE;
        @(negedge clk); data_vld = 1'b0;
        check(ack === 1'b0, "R10 no ack while busy", ack, 0);
        wait_idle(n);
        check(wr_n == 1, "R10 busy strobes add no write", wr_n, 1);
        check_mem(7'h50, "R10 committed byte");
        check_mem(7'h60, "R10 ignored address untouched");
        check_mem(7'h51, "R10 ignored byte not appended");
    endtask

    task automatic t_same_cycle();
        begin_txn(8'h70);
        send_byte(8'h0A); exp_m[7'h70] = 8'h0A;
        exp_m[7'h71] = 8'h0B;
        end_txn(1, 8'h0B);
        check(wr_n == 2, "R11 both bytes written", wr_n, 2);
        check_mem(7'h70, "R11 first byte");
        check_mem(7'h71, "R11 byte with stop");
    endtask

    initial begin
        for (int a = 0; a < 128; a++) begin obs[a] = 8'h00; exp_m[a] = 8'h00; end
        order_ok = 1'b1; first_wr = '0; last_wr = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_page();
        t_partial_wrap();
        t_overrun();
        t_abort();
        t_empty_stop();
        t_ignored();
        t_same_cycle();
        summary();
    end
endmodule